// File: doc/BRIEF.md
# I2C Pin Takeover Mux for Bus Recovery

This block sits between an I2C controller core and the two open-drain bus pins. In normal operation the core's pull-low requests for the clock and data lines pass straight through to the pad drivers. When the core gets stuck, software sets one mode bit. Both pins then come under a small GPIO path, which software uses to clock a hung target free.

In GPIO mode, each pin has a direction bit and an output latch. The latch is changed only through a write-one-to-set register and a write-one-to-clear register, so software never needs a read-modify-write to move one line. A status register returns the synchronized pin levels, so software can watch the data line while it toggles the clock. The usual recovery setup makes the clock line an output and the data line an input. The drive outputs are pull-low enables. A pin is never driven high.

Top module: `i2c_pin_recovery_mux`

## Requirements
- R1: After reset, the mode bit is 0, both direction bits are 0 and both output latches are 1. The status register reads 2'b11 until pin samples have passed through the synchronizer.
- R2: With the mode bit at 0, `scl_pull_low` equals `core_scl_pull` and `sda_pull_low` equals `core_sda_pull` in the same cycle.
- R3: With the mode bit at 1, a pin is pulled low exactly when its direction bit is 1 and its latch is 0. The core's requests have no effect.
- R4: Direction bit 0 (address 1) belongs to the clock line and bit 1 belongs to the data line. A pin whose direction bit is 0 is released in GPIO mode.
- R5: A write to address 3 sets each latch whose data bit (bit 0 clock, bit 1 data) is 1. Latches whose bit is 0 keep their value. The change takes effect from the clock edge of the write.
- R6: A write to address 4 clears each latch whose data bit is 1. Latches whose bit is 0 keep their value.
- R7: Address 2 reads the clock pin level on bit 0 and the data pin level on bit 1. A pin change appears there after two rising clock edges.
- R8: The read map is as follows. Address 0 returns the mode bit on bit 0. Address 1 returns the direction bits. Address 3 returns the latches on bits 1:0. Address 4 and addresses 5 to 7 return 0. All unused bits read 0.
- R9: Writes to address 2 and to addresses 5 to 7 change nothing. Of a write to address 0, only bit 0 is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Write address |
| reg_wr_data | input | DATA_W | Write data |
| reg_rd_addr | input | ADDR_W | Read address |
| reg_rd_data | output | DATA_W | Read data, combinational from the read address |
| core_scl_pull | input | 1 | Core request to pull the clock line low |
| core_sda_pull | input | 1 | Core request to pull the data line low |
| scl_pin_in | input | 1 | Clock line level at the pad |
| sda_pin_in | input | 1 | Data line level at the pad |
| scl_pull_low | output | 1 | Pull-low enable for the clock pad |
| sda_pull_low | output | 1 | Pull-low enable for the data pad |

## Verification
The hardest condition to reach is a set or clear write that lands while the core is also requesting a pull, with the mode switching a cycle later. The latch moves even in I2C mode, and only the next mode change reveals whether a write with zero bits disturbed it. The stimulus therefore interleaves set, clear, mode and direction writes with random core requests and pin levels. The read address sweeps every location each cycle. A behavioural model with a two-deep pin history is compared on every clock against both pad outputs and the read data.

// File: rtl/i2c_pin_recovery_mux.sv
module i2c_pin_recovery_mux #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              core_scl_pull,
  input  logic              core_sda_pull,
  input  logic              scl_pin_in,
  input  logic              sda_pin_in,
  output logic              scl_pull_low,
  output logic              sda_pull_low
);

  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(4);

  logic       gpio_mode_q;
  logic [1:0] dir_q;
  logic [1:0] latch_q;
  logic [1:0] sync_q [SYNC_STAGES];
  logic [1:0] pin_sync;

  wire wr_mode = reg_wr_en && reg_wr_addr == A_MODE;
  wire wr_dir  = reg_wr_en && reg_wr_addr == A_DIR;
  wire wr_set  = reg_wr_en && reg_wr_addr == A_SET;
  wire wr_clr  = reg_wr_en && reg_wr_addr == A_CLR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpio_mode_q <= 1'b0;
      dir_q       <= 2'b00;
      latch_q     <= 2'b11;
    end else begin
      if (wr_mode) gpio_mode_q <= reg_wr_data[0];
      if (wr_dir)  dir_q       <= reg_wr_data[1:0];
      latch_q <= (latch_q | ({2{wr_set}} & reg_wr_data[1:0]))
                 & ~({2{wr_clr}} & reg_wr_data[1:0]);
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n)      sync_q[s] <= 2'b11;
      else if (s == 0) sync_q[s] <= {sda_pin_in, scl_pin_in};
      else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end
  assign pin_sync = sync_q[SYNC_STAGES-1];

  wire [1:0] gpio_pull = dir_q & ~latch_q;
  assign scl_pull_low = gpio_mode_q ? gpio_pull[0] : core_scl_pull;
  assign sda_pull_low = gpio_mode_q ? gpio_pull[1] : core_sda_pull;

  always_comb begin
    reg_rd_data = '0;
    case (reg_rd_addr)
      A_MODE:  reg_rd_data[0]   = gpio_mode_q;
      A_DIR:   reg_rd_data[1:0] = dir_q;
      A_STAT:  reg_rd_data[1:0] = pin_sync;
      A_SET:   reg_rd_data[1:0] = latch_q;
      default: reg_rd_data = '0;
    endcase
  end

endmodule

// File: rtl/i2c_pin_recovery_mux_chk.sv
module i2c_pin_recovery_mux_chk #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_wr_addr,
  input logic [DATA_W-1:0] reg_wr_data,
  input logic              core_scl_pull,
  input logic              scl_pin_in,
  input logic              sda_pin_in,
  input logic              scl_pull_low,
  input logic              sda_pull_low,
  input logic              gpio_mode_q,
  input logic [1:0]        dir_q,
  input logic [1:0]        latch_q,
  input logic [1:0]        pin_sync
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r1_reset_latch: assert property (@(posedge clk)
    !rst_n |=> (latch_q == 2'b11 && !gpio_mode_q && dir_q == 2'b00));

  a_r2_core_path: assert property (@(posedge clk) disable iff (!rst_n)
    !gpio_mode_q |-> (scl_pull_low == core_scl_pull));

  a_r3_released: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_mode_q && latch_q[1]) |-> !sda_pull_low);

  a_r4_input_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_mode_q && !dir_q[0]) |-> !scl_pull_low);

  a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_addr == ADDR_W'(3) && reg_wr_data[0]) |=> latch_q[0]);

  a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_addr == ADDR_W'(3) && !reg_wr_data[1]) |=> $stable(latch_q[1]));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_addr == ADDR_W'(4) && reg_wr_data[1]) |=> !latch_q[1]);

  a_r9_stat_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_addr == ADDR_W'(2)) |=> ($stable(latch_q) && $stable(dir_q) && $stable(gpio_mode_q)));

  if (SYNC_STAGES == 2) begin : g_lat
    a_r7_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2) |-> (pin_sync == $past({sda_pin_in, scl_pin_in}, 2)));
  end
endmodule

bind i2c_pin_recovery_mux i2c_pin_recovery_mux_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
  .reg_wr_data(reg_wr_data), .core_scl_pull(core_scl_pull),
  .scl_pin_in(scl_pin_in), .sda_pin_in(sda_pin_in),
  .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low),
  .gpio_mode_q(gpio_mode_q), .dir_q(dir_q), .latch_q(latch_q), .pin_sync(pin_sync)
);

// File: tb/i2c_pin_recovery_mux_tb.sv
module i2c_pin_recovery_mux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        c_scl = 1'b0, c_sda = 1'b0, p_scl = 1'b1, p_sda = 1'b1;
  logic        o_scl, o_sda;

  int compared = 0, mismatched = 0, cycles = 0;
  string tag = "R1";

  i2c_pin_recovery_mux u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_addr(wr_addr),
    .reg_wr_data(wr_data), .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
    .core_scl_pull(c_scl), .core_sda_pull(c_sda),
    .scl_pin_in(p_scl), .sda_pin_in(p_sda),
    .scl_pull_low(o_scl), .sda_pull_low(o_sda));

  always #10 clk = ~clk;

  // reference model
  bit        m_mode;
  bit [1:0]  m_dir, m_latch;
  bit [1:0]  pin_hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_dir = 0; m_latch = 2'b11;
      pin_hist = '{2'b11, 2'b11};
    end else begin
      pin_hist.push_front({p_sda, p_scl});
      void'(pin_hist.pop_back());
      if (wr_en) begin
        if (wr_addr == 3'd0) m_mode = wr_data[0];
        else if (wr_addr == 3'd1) m_dir = wr_data[1:0];
        else if (wr_addr == 3'd3) m_latch = m_latch | wr_data[1:0];
        else if (wr_addr == 3'd4) m_latch = m_latch & ~wr_data[1:0];
      end
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step();
    logic [15:0] exp_rd;
    bit e_scl, e_sda;
    @(negedge clk);
    #2;
    exp_rd = '0;
    case (rd_addr)
      3'd0: exp_rd[0] = m_mode;
      3'd1: exp_rd[1:0] = m_dir;
      3'd2: exp_rd[1:0] = pin_hist[1];
      3'd3: exp_rd[1:0] = m_latch;
      default: exp_rd = '0;
    endcase
    e_scl = m_mode ? (m_dir[0] & ~m_latch[0]) : c_scl;
    e_sda = m_mode ? (m_dir[1] & ~m_latch[1]) : c_sda;
    check({tag, (rd_addr == 3'd2) ? " R7" : " R8"}, rd_data, exp_rd);
    check({tag, m_mode ? " R3 R4 scl" : " R2 scl"}, 16'(o_scl), 16'(e_scl));
    check({tag, m_mode ? " R3 R4 sda" : " R2 sda"}, 16'(o_sda), 16'(e_sda));
    rd_addr = rd_addr + 3'd1;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    tag = "R1";
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'hFFFF;
    repeat (3) step();
    @(negedge clk); wr_en = 1'b0; rst_n = 1'b1;
    for (int i = 0; i < 8; i++) step();

    tag = "R2";
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); {c_sda, c_scl} = 2'(i);
      step();
    end

    tag = "R9 mode-upper";
    wr(3'd0, 16'hFFFE);
    for (int i = 0; i < 8; i++) step();

    tag = "R4 R3 recovery";
    wr(3'd1, 16'h0001);
    wr(3'd0, 16'h0001);
    c_scl = 1'b1; c_sda = 1'b1;
    for (int i = 0; i < 3; i++) step();
    for (int k = 0; k < 4; k++) begin
      tag = "R6 clear"; wr(3'd4, 16'h0001); step(); step();
      tag = "R5 set";   wr(3'd3, 16'h0001); step(); step();
    end

    tag = "R5 R6 zero-bits";
    wr(3'd1, 16'h0003);
    wr(3'd4, 16'h0002); step();
    wr(3'd3, 16'h0001); step();
    wr(3'd4, 16'h0000); step();
    wr(3'd3, 16'h0000); step();
    wr(3'd4, 16'hFFFC); step();
    wr(3'd3, 16'h0002); step();

    tag = "R7 pins";
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); {p_sda, p_scl} = 2'(i * 3 + (i >> 2));
      step();
    end

    tag = "R9 ignored";
    wr(3'd4, 16'h0003);
    wr(3'd2, 16'hFFFF); for (int i = 0; i < 8; i++) step();
    wr(3'd5, 16'hFFFF); wr(3'd6, 16'h0000); wr(3'd7, 16'hFFFF);
    for (int i = 0; i < 8; i++) step();

    tag = "R2 back";
    wr(3'd0, 16'h0000);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); {c_sda, c_scl} = 2'(i + 1);
      step();
    end

    tag = "mixed R5 R6 R3";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      {c_sda, c_scl} = 2'($urandom);
      {p_sda, p_scl} = 2'($urandom);
      wr_en = ($urandom % 3) == 0;
      wr_addr = 3'($urandom);
      wr_data = 16'($urandom);
      rd_addr = 3'($urandom);
      step();
    end
    @(negedge clk); wr_en = 1'b0;

    tag = "R1 re-reset";
    rst_n = 1'b0; step(); step();
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule